// File: doc/BRIEF.md
# Frequency-Locked Loop Digital Controller

This block is the digital half of a frequency-locked loop. A free-running oscillator clock is fed back to it. A counter in the oscillator domain counts its rising edges between two consecutive sampling ticks from the system clock domain. A toggle handshake carries each finished count into the system domain. On every enabled tick the block subtracts the most recent finished count from a reference count. It scales that error by a programmable power-of-two gain and adds the result into a clamped integral accumulator. The upper bits of the accumulator drive the oscillator's 8-bit control code.

The loop closes outside the block: the control code sets the oscillator frequency, and that frequency sets the next count. Each measurement becomes usable only after the tick that closes its window. The control law therefore always acts on an error that is one sample old. A lock flag reports when the error has stayed within a programmable tolerance for several samples in a row. Pulling the enable low parks the loop at mid-scale.

Top module: `freq_lock_ctrl`

## Requirements
- R1: While reset is held, `ctrlCode` is 128, `locked` is 0 and `measCount` is 0.
- R2: At any clock edge where `enable` is low, the accumulator is preset to mid-scale (2048 of 4095). From the following cycle `ctrlCode` reads 128 and `locked` is 0.
- R3: While `enable` is high, `ctrlCode` changes only at a clock edge where `sampleTick` is high.
- R4: At an enabled tick edge, the error is `refCount - measCount` as a signed value, using the `measCount` present just before that edge. The error is shifted and added to a 12-bit accumulator. `ctrlCode` is accumulator bits [11:4].
- R5: The sum is clamped to the range 0 to 4095 and never wraps. A code of 255 with a positive error stays 255, and a code of 0 with a negative error stays 0.
- R6: `measCount` is the number of oscillator rising edges between two consecutive ticks. It is updated within a few cycles after the tick that closes that window. The update at the next tick therefore uses it, which gives a lag of one sample.
- R7: `locked` is set at the tick edge of the fourth consecutive enabled update whose error magnitude is at most `lockTol`. It stays set while further updates remain within tolerance.
- R8: Any enabled update whose error magnitude exceeds `lockTol` clears `locked` and restarts the run of in-tolerance samples.
- R9: The gain is an arithmetic right shift of the error by `gainShift` (0 to 7), which rounds toward minus infinity. A small positive error can therefore add 0, and any negative error adds at least -1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| oscClk | input | 1 | Clock from the controlled oscillator |
| sampleTick | input | 1 | One-cycle pulse closing a measurement window |
| enable | input | 1 | Loop enable; low presets the code to mid-scale |
| refCount | input | CW (10) | Target edge count per window |
| gainShift | input | 3 | Right-shift amount applied to the error |
| lockTol | input | CW (10) | Largest error magnitude counted as in tolerance |
| ctrlCode | output | 8 | Oscillator control code |
| measCount | output | CW (10) | Last completed window's edge count |
| locked | output | 1 | Lock indication |

## Verification
The bench uses the default parameters: 10-bit counts, a 12-bit accumulator and a four-sample lock run. Ticks come every 64 system cycles, and the oscillator model runs at 100 + 2·code MHz. With these values a window holds roughly 32 to 195 edges. A reference of 1000 is out of reach and drives the code to the top clamp, and a reference of 0 drives it to the bottom clamp. A shift of 7 makes small positive errors vanish, while negative errors still step the accumulator down. A reachable reference of 150 with a tolerance of 2 lets the loop settle and produce the lock flag, which a following large error then clears.

// File: rtl/flc_pkg.sv
`timescale 1ns/1ps
package flc_pkg;
  // Strobes passed from the control unit to the datapath
  typedef struct packed {
    logic preset;  // park accumulator at mid-scale
    logic update;  // apply one integral step
  } flcStrobe_t;
endpackage

// File: rtl/flc_sensor.sv
`timescale 1ns/1ps
module flc_sensor #(
  parameter int CW = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          oscClk,
  input  logic          sampleTick,
  output logic [CW-1:0] measCount
);
  localparam int SL = SYNC_STAGES + 1;
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic          reqTgl;
  logic [SL-1:0] reqSync;
  logic          reqEdge;
  logic [CW-1:0] edgeCnt;
  logic [CW-1:0] holdCnt;
  logic          ackTgl;
  logic [SL-1:0] ackSync;
  logic          ackEdge;

  // system domain: each tick flips the request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqTgl <= 1'b0;
    else if (sampleTick) reqTgl <= ~reqTgl;
  end

  // oscillator domain: synchronise request, count edges, snapshot on request
  always_ff @(posedge oscClk or negedge rstN) begin
    if (!rstN) reqSync <= '0;
    else reqSync <= {reqSync[SL-2:0], reqTgl};
  end
  assign reqEdge = reqSync[SL-1] ^ reqSync[SL-2];

  always_ff @(posedge oscClk or negedge rstN) begin
    if (!rstN) begin
      edgeCnt <= '0;
      holdCnt <= '0;
      ackTgl  <= 1'b0;
    end else if (reqEdge) begin
      holdCnt <= edgeCnt;
      edgeCnt <= CW'(1);
      ackTgl  <= ~ackTgl;
    end else if (edgeCnt != CNT_MAX) begin
      edgeCnt <= edgeCnt + 1'b1;
    end
  end

  // system domain: acknowledge marks holdCnt as settled
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ackSync <= '0;
    else ackSync <= {ackSync[SL-2:0], ackTgl};
  end
  assign ackEdge = ackSync[SL-1] ^ ackSync[SL-2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) measCount <= '0;
    else if (ackEdge) measCount <= holdCnt;
  end
endmodule

// File: rtl/flc_datapath.sv
`timescale 1ns/1ps
module flc_datapath
  import flc_pkg::*;
#(
  parameter int CW = 10,
  parameter int AW = 12,
  parameter int OW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  flcStrobe_t    strobe,
  input  logic [CW-1:0] refCount,
  input  logic [CW-1:0] measCount,
  input  logic [2:0]    gainShift,
  input  logic [CW-1:0] lockTol,
  output logic [OW-1:0] ctrlCode,
  output logic          inTol
);
  localparam int EW = CW + 1;
  localparam int SW = ((AW > EW) ? AW : EW) + 2;
  localparam logic [AW-1:0] ACC_MID = AW'(1) << (AW - 1);

  logic        [AW-1:0] accReg;
  logic signed [EW-1:0] errVal;
  logic signed [EW-1:0] errShift;
  logic        [EW-1:0] errMag;
  logic signed [SW-1:0] sumVal;
  logic signed [SW-1:0] sumMax;
  logic        [AW-1:0] accNext;

  always_comb begin
    errVal   = $signed({1'b0, refCount}) - $signed({1'b0, measCount});
    errShift = errVal >>> gainShift;
    errMag   = errVal[EW-1] ? $unsigned(-errVal) : $unsigned(errVal);
    inTol    = (errMag <= {1'b0, lockTol});
    sumMax   = $signed({{(SW-AW){1'b0}}, {AW{1'b1}}});
    sumVal   = $signed({{(SW-AW){1'b0}}, accReg})
             + $signed({{(SW-EW){errShift[EW-1]}}, errShift});
    if (sumVal < 0)           accNext = '0;
    else if (sumVal > sumMax) accNext = {AW{1'b1}};
    else                      accNext = sumVal[AW-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              accReg <= ACC_MID;
    else if (strobe.preset) accReg <= ACC_MID;
    else if (strobe.update) accReg <= accNext;
  end

  assign ctrlCode = accReg[AW-1 -: OW];
endmodule

// File: rtl/flc_control.sv
`timescale 1ns/1ps
module flc_control
  import flc_pkg::*;
#(
  parameter int LOCK_RUN = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       sampleTick,
  input  logic       inTol,
  output flcStrobe_t strobe,
  output logic       locked
);
  localparam int RW = $clog2(LOCK_RUN + 1);
  localparam logic [RW-1:0] RUN_END = RW'(LOCK_RUN);

  logic [RW-1:0] runCnt;

  always_comb begin
    strobe.preset = ~enable;
    strobe.update = enable & sampleTick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
      locked <= 1'b0;
    end else if (strobe.preset) begin
      runCnt <= '0;
      locked <= 1'b0;
    end else if (strobe.update) begin
      if (inTol) begin
        if (runCnt != RUN_END) runCnt <= runCnt + 1'b1;
        locked <= (runCnt >= RUN_END - 1'b1);
      end else begin
        runCnt <= '0;
        locked <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/freq_lock_ctrl.sv
`timescale 1ns/1ps
module freq_lock_ctrl
  import flc_pkg::*;
#(
  parameter int CW = 10,
  parameter int AW = 12,
  parameter int OW = 8,
  parameter int LOCK_RUN = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          oscClk,
  input  logic          sampleTick,
  input  logic          enable,
  input  logic [CW-1:0] refCount,
  input  logic [2:0]    gainShift,
  input  logic [CW-1:0] lockTol,
  output logic [OW-1:0] ctrlCode,
  output logic [CW-1:0] measCount,
  output logic          locked
);
  flcStrobe_t strobe;
  logic       inTol;

  flc_sensor #(.CW(CW), .SYNC_STAGES(SYNC_STAGES)) sensor_i (
    .clk(clk), .rstN(rstN), .oscClk(oscClk),
    .sampleTick(sampleTick), .measCount(measCount)
  );

  flc_control #(.LOCK_RUN(LOCK_RUN)) control_i (
    .clk(clk), .rstN(rstN), .enable(enable), .sampleTick(sampleTick),
    .inTol(inTol), .strobe(strobe), .locked(locked)
  );

  flc_datapath #(.CW(CW), .AW(AW), .OW(OW)) datapath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .refCount(refCount),
    .measCount(measCount), .gainShift(gainShift), .lockTol(lockTol),
    .ctrlCode(ctrlCode), .inTol(inTol)
  );
endmodule

// File: rtl/freq_lock_ctrl_chk.sv
`timescale 1ns/1ps
module freq_lock_ctrl_chk #(
  parameter int CW = 10,
  parameter int OW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          sampleTick,
  input logic          enable,
  input logic [CW-1:0] refCount,
  input logic [CW-1:0] lockTol,
  input logic [OW-1:0] ctrlCode,
  input logic [CW-1:0] measCount,
  input logic          locked
);
  localparam logic [OW-1:0] MID = OW'(1) << (OW - 1);
  localparam logic [OW-1:0] TOP = {OW{1'b1}};

  logic signed [CW+1:0] diff;
  logic        [CW+1:0] diffMag;
  always_comb begin
    diff    = $signed({2'b00, refCount}) - $signed({2'b00, measCount});
    diffMag = diff[CW+1] ? $unsigned(-diff) : $unsigned(diff);
  end

  assert_preset_R2: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (ctrlCode == MID) && !locked);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !sampleTick) |=> $stable(ctrlCode));

  assert_clamp_top_R5: assert property (@(posedge clk) disable iff (!rstN)
    (enable && sampleTick && ctrlCode == TOP && refCount > measCount) |=> ctrlCode == TOP);

  assert_clamp_bottom_R5: assert property (@(posedge clk) disable iff (!rstN)
    (enable && sampleTick && ctrlCode == '0 && refCount < measCount) |=> ctrlCode == '0);

  assert_lock_at_tick_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(enable && sampleTick));

  assert_lock_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (enable && sampleTick && diffMag > {2'b00, lockTol}) |=> !locked);
endmodule

bind freq_lock_ctrl freq_lock_ctrl_chk #(.CW(CW), .OW(OW)) chk_i (
  .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .enable(enable),
  .refCount(refCount), .lockTol(lockTol), .ctrlCode(ctrlCode),
  .measCount(measCount), .locked(locked)
);

// File: tb/freq_lock_ctrl_tb_top.sv
`timescale 1ns/1ps
module freq_lock_ctrl_tb_top;
  localparam int CW  = 10;
  localparam int WIN = 64;

  logic clk = 1'b0, rstN = 1'b0, oscClk = 1'b0;
  logic sampleTick = 1'b0, enable = 1'b0;
  logic [CW-1:0] refCount = '0, lockTol = '0;
  logic [2:0] gainShift = '0;
  logic [7:0] ctrlCode;
  logic [CW-1:0] measCount;
  logic locked;

  freq_lock_ctrl dut_i (
    .clk(clk), .rstN(rstN), .oscClk(oscClk), .sampleTick(sampleTick),
    .enable(enable), .refCount(refCount), .gainShift(gainShift),
    .lockTol(lockTol), .ctrlCode(ctrlCode), .measCount(measCount),
    .locked(locked)
  );

  always #2.5 clk = ~clk;
  // oscillator model: 100 + 2*code MHz
  always begin
    #(500.0 / (100.0 + 2.0 * real'(ctrlCode)));
    oscClk = ~oscClk;
  end

  int errors = 0, checks = 0;
  int mAcc = 2048, mRun = 0;
  bit mLock = 0, everLocked = 0;
  longint cyc = 0, tickA = -1000, tickB = -1000, lastChange = 0;
  int lastCode = 128;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int clampAcc(input int v);
    return (v < 0) ? 0 : ((v > 4095) ? 4095 : v);
  endfunction

  // one system cycle; inputs are already set at a falling edge
  task automatic doCycle();
    int m = int'(measCount);
    bit en = enable, tk = sampleTick;
    int r = int'(refCount), sh = int'(gainShift), tl = int'(lockTol);
    if (tk && tickB > 0 && lastChange + 2 < tickB) begin
      real e = real'(WIN) * 5.0 * (100.0 + 2.0 * real'(lastCode)) / 1000.0;
      real d = real'(m) - e;
      check(d <= 2.0 && d >= -2.0, "R6 window count", m, int'(e));
    end
    @(posedge clk);
    cyc++;
    if (!en) begin
      mAcc = 2048; mRun = 0; mLock = 0;
    end else if (tk) begin
      int err = r - m;
      int mag = (err < 0) ? -err : err;
      mAcc = clampAcc(mAcc + (err >>> sh));
      if (mag <= tl) begin
        if (mRun < 4) mRun++;
        mLock = (mRun == 4);
      end else begin
        mRun = 0; mLock = 0;
      end
    end
    if (tk) begin tickB = tickA; tickA = cyc; end
    @(negedge clk);
    if (int'(ctrlCode) != lastCode) begin lastChange = cyc; lastCode = int'(ctrlCode); end
    if (mLock) everLocked = 1;
    if (!en) begin
      check(ctrlCode == 8'(mAcc >> 4), "R2 preset code", ctrlCode, mAcc >> 4);
      check(locked == mLock, "R2 lock cleared", locked, mLock);
    end else if (tk) begin
      check(ctrlCode == 8'(mAcc >> 4), (sh != 0) ? "R9 shifted update" : "R4 integral update",
            ctrlCode, mAcc >> 4);
      check(locked == mLock, "R7 R8 lock flag", locked, mLock);
    end else begin
      check(ctrlCode == 8'(mAcc >> 4), "R3 code held", ctrlCode, mAcc >> 4);
    end
  endtask

  task automatic runWindows(input int n);
    repeat (n) begin
      sampleTick = 1'b1;
      doCycle();
      sampleTick = 1'b0;
      repeat (WIN - 1) doCycle();
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(ctrlCode == 8'd128, "R1 reset code", ctrlCode, 128);
    check(locked == 1'b0, "R1 reset lock", locked, 0);
    check(measCount == '0, "R1 reset count", measCount, 0);
    rstN = 1'b1;
    @(negedge clk);
    lastCode = int'(ctrlCode);

    // parked loop
    runWindows(3);

    // reachable target: settles and locks
    enable = 1'b1; refCount = 10'd150; gainShift = 3'd0; lockTol = 10'd2;
    runWindows(250);
    check(everLocked == 1'b1, "R7 lock reached", everLocked, 1);

    // unreachable target: lock drops, code pinned at top
    refCount = 10'd1000;
    runWindows(1);
    check(locked == 1'b0, "R8 lock dropped", locked, 0);
    runWindows(80);
    check(ctrlCode == 8'd255, "R5 top clamp", ctrlCode, 255);

    // zero target: pinned at bottom
    refCount = 10'd0;
    runWindows(80);
    check(ctrlCode == 8'd0, "R5 bottom clamp", ctrlCode, 0);

    // coarse gain from mid-scale
    enable = 1'b0;
    runWindows(1);
    enable = 1'b1; gainShift = 3'd7; refCount = 10'd20;
    runWindows(10);
    refCount = 10'd200;
    runWindows(10);

    // constrained random segments
    void'($urandom(32'd20240611));
    for (int seg = 0; seg < 30; seg++) begin
      refCount  = CW'(40 + $urandom % 160);
      gainShift = 3'($urandom % 8);
      lockTol   = CW'($urandom % 6);
      enable    = ($urandom % 8) != 0;
      runWindows(8);
    end

    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    summary();
    $finish;
  end
endmodule